// File: doc/BRIEF.md
# Age-Ordered Dispatch Buffer

This block sits between the register-map stage and a set of per-port schedulers. Each cycle the map stage may present a group of renamed operations. Each operation carries a payload and a mask of the schedulers allowed to take it. Every accepted operation is written into one shared circular buffer, and nothing reaches a scheduler by any other route. Each cycle the buffer looks at its oldest entries and forwards them in strict age order, one per issue lane. An entry leaves only when every older entry leaves in the same cycle and one of its allowed schedulers still reports space. Operand readiness plays no part in this decision; wakeup and select are left to the schedulers.

Each scheduler reports how many operations it can take this cycle. An operation allowed on several schedulers goes to the lowest-numbered one that still has room after the older operations issued in the same cycle have taken theirs. Every stored operation carries an age tag equal to its arrival order modulo 2^AGE_W. The tag goes out with the operation so that a downstream scheduler can order it.

An occupancy state machine has three states: EMPTY (no entries), OPEN (entries present, group accepted), and CHOKED (occupancy above DEPTH-ENQ_W, map stalled). It has four named transitions: FILL (EMPTY to OPEN), CHOKE (OPEN or EMPTY to CHOKED), RELIEVE (CHOKED to OPEN) and DRAIN (OPEN or CHOKED to EMPTY). The state is computed from the occupancy at the next cycle, so it always matches the stored count.

Top module: `age_dispatch_buf`

## Requirements
- R1: After reset the buffer is empty: no issue lane is valid, map_stall is low, and the first operation accepted carries age tag 0.
- R2: An operation presented by map in cycle t is never issued in cycle t, even when the buffer is empty and its scheduler has space.
- R3: Issue lanes are filled from lane 0 upward with consecutive oldest entries: lane k is valid only if lane k-1 is valid, and lane 0 always carries the oldest stored operation.
- R4: If the oldest entry has no allowed scheduler with space, no lane issues, even when a younger entry's scheduler has space.
- R5: Each issuing operation targets the lowest-indexed scheduler s whose bit s is set in its mask and whose remaining space is above zero. Remaining space starts at sched_space[s] and drops by one for each older operation issued to s in the same cycle. iss_sched gives s as a binary index.
- R6: An operation at the head of the buffer whose allowed scheduler reports space issues in that cycle; no readiness condition delays it, so an operation presented to an empty buffer in cycle t issues in cycle t+1 when space is offered.
- R7: At most DEQ_W operations issue per cycle.
- R8: Valid map lanes are stored in lane order, and a lower lane counts as older. Invalid lanes may sit between valid ones and take no entry. The payload is returned unchanged on issue.
- R9: map_stall is high exactly when the occupancy at the start of the cycle exceeds DEPTH-ENQ_W. A group presented while map_stall is high is dropped and never issued.
- R10: Age tags run consecutively modulo 2^AGE_W in acceptance order and wrap around, so operations issued in one cycle carry consecutive tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| map_valid | input | ENQ_W | Per-lane valid from map; lower lane is older |
| map_mask | input | ENQ_W x NSCHED | Per-lane mask of allowed schedulers, bit s for scheduler s |
| map_data | input | ENQ_W x DATA_W | Per-lane operation payload |
| map_stall | output | 1 | High when the presented group is not accepted |
| sched_space | input | NSCHED x SP_W | Number of operations each scheduler can take this cycle |
| iss_valid | output | DEQ_W | Per-lane issue valid, lane 0 oldest |
| iss_sched | output | DEQ_W x SEL_W | Target scheduler index per lane |
| iss_data | output | DEQ_W x DATA_W | Payload per lane |
| iss_age | output | DEQ_W x AGE_W | Age tag per lane |

## Verification
A wrong head or tail pointer shows up on the very next issue. A skipped or repeated entry leaves a gap or a duplicate in the payload and age sequence that the schedulers receive. An occupancy count that drifts from the real contents shows within a few cycles: map_stall rises or falls at the wrong fill level, or a lane issues from an empty buffer or stays silent with entries waiting. A broken age ordering shows as soon as a stuck oldest entry sits in front of a younger one that could move: the younger one leaves early, or space is assigned to the wrong scheduler.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY  = 2'd0,
        OCC_OPEN   = 2'd1,
        OCC_CHOKED = 2'd2
    } occ_state_e;

endpackage

// File: rtl/dbuf_occ_fsm.sv
module dbuf_occ_fsm
    import dbuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ENQ_W  = 4,
    parameter int CNT_W  = 5,
    parameter int IN_CW  = 3,
    parameter int OUT_CW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_CW-1:0]  n_push,
    input  logic [OUT_CW-1:0] n_pop,
    output logic [CNT_W-1:0]  count,
    output occ_state_e        state,
    output logic              map_stall
);
    localparam int LIMIT = DEPTH - ENQ_W;

    logic [CNT_W-1:0] count_d;
    occ_state_e       state_d;

    function automatic occ_state_e classify(input logic [CNT_W-1:0] c);
        if (c == '0)
            return OCC_EMPTY;
        else if (int'(c) > LIMIT)
            return OCC_CHOKED;
        else
            return OCC_OPEN;
    endfunction

    // next occupancy and the state it implies (FILL, CHOKE, RELIEVE, DRAIN)
    always_comb begin
        count_d = CNT_W'(int'(count) + int'(n_push) - int'(n_pop));
        state_d = classify(count_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            state <= OCC_EMPTY;
        end else begin
            count <= count_d;
            state <= state_d;
        end
    end

    always_comb begin
        unique case (state)
            OCC_EMPTY:  map_stall = 1'b0;
            OCC_OPEN:   map_stall = 1'b0;
            OCC_CHOKED: map_stall = 1'b1;
            default:    map_stall = 1'b1;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R9
    AST_STALL_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        map_stall |=> count <= $past(count)); // R9

endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
    parameter int DEPTH  = 16,
    parameter int ENQ_W  = 4,
    parameter int DEQ_W  = 2,
    parameter int NSCHED = 4,
    parameter int DATA_W = 16,
    parameter int AGE_W  = 5,
    parameter int IN_CW  = 3,
    parameter int OUT_CW = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [ENQ_W-1:0]              in_valid,
    input  logic [ENQ_W-1:0][NSCHED-1:0]  in_mask,
    input  logic [ENQ_W-1:0][DATA_W-1:0]  in_data,
    input  logic [OUT_CW-1:0]             n_pop,
    output logic [IN_CW-1:0]              n_push,
    output logic [DEQ_W-1:0][NSCHED-1:0]  pk_mask,
    output logic [DEQ_W-1:0][DATA_W-1:0]  pk_data,
    output logic [DEQ_W-1:0][AGE_W-1:0]   pk_age
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]  head_q;
    logic [PTR_W-1:0]  tail_q;
    logic [AGE_W-1:0]  age_q;
    logic [NSCHED-1:0] mem_mask [DEPTH];
    logic [DATA_W-1:0] mem_data [DEPTH];
    logic [AGE_W-1:0]  mem_age  [DEPTH];
    logic [IN_CW-1:0]  slot     [ENQ_W];

    // compaction: each valid lane lands after the valid lanes below it
    always_comb begin
        logic [IN_CW-1:0] run;
        run = '0;
        for (int i = 0; i < ENQ_W; i++) begin
            slot[i] = run;
            run     = run + IN_CW'(in_valid[i]);
        end
        n_push = accept ? run : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            age_q  <= '0;
        end else begin
            head_q <= head_q + PTR_W'(n_pop);
            tail_q <= tail_q + PTR_W'(n_push);
            age_q  <= age_q + AGE_W'(n_push);
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < ENQ_W; i++) begin
                if (in_valid[i]) begin
                    mem_mask[tail_q + PTR_W'(slot[i])] <= in_mask[i];
                    mem_data[tail_q + PTR_W'(slot[i])] <= in_data[i];
                    mem_age[tail_q + PTR_W'(slot[i])]  <= age_q + AGE_W'(slot[i]);
                end
            end
        end
    end

    always_comb begin
        for (int k = 0; k < DEQ_W; k++) begin
            pk_mask[k] = mem_mask[head_q + PTR_W'(k)];
            pk_data[k] = mem_data[head_q + PTR_W'(k)];
            pk_age[k]  = mem_age[head_q + PTR_W'(k)];
        end
    end

endmodule

// File: rtl/dbuf_pick.sv
module dbuf_pick #(
    parameter int DEQ_W  = 2,
    parameter int NSCHED = 4,
    parameter int SP_W   = 2,
    parameter int SEL_W  = 2,
    parameter int AGE_W  = 5,
    parameter int OUT_CW = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEQ_W-1:0]              cand_valid,
    input  logic [DEQ_W-1:0][NSCHED-1:0]  cand_mask,
    input  logic [DEQ_W-1:0][AGE_W-1:0]   cand_age,
    input  logic [NSCHED-1:0][SP_W-1:0]   sched_space,
    output logic [DEQ_W-1:0]              go,
    output logic [DEQ_W-1:0][SEL_W-1:0]  sel,
    output logic [OUT_CW-1:0]             n_pop
);
    logic [NSCHED-1:0][DEQ_W-1:0] hit;

    // strict oldest-first: a lane moves only if every older lane moved
    always_comb begin
        int  rem [NSCHED];
        int  pick;
        logic chain;
        chain = 1'b1;
        for (int s = 0; s < NSCHED; s++) rem[s] = int'(sched_space[s]);
        for (int k = 0; k < DEQ_W; k++) begin
            go[k]  = 1'b0;
            sel[k] = '0;
            pick   = -1;
            if (chain && cand_valid[k]) begin
                for (int s = 0; s < NSCHED; s++) begin
                    if (pick < 0 && cand_mask[k][s] && rem[s] > 0) pick = s;
                end
            end
            if (pick >= 0) begin
                go[k]     = 1'b1;
                sel[k]    = SEL_W'(pick);
                rem[pick] = rem[pick] - 1;
            end
            chain = go[k];
        end
        n_pop = OUT_CW'($countones(go));
    end

    always_comb begin
        for (int s = 0; s < NSCHED; s++)
            for (int k = 0; k < DEQ_W; k++)
                hit[s][k] = go[k] && (int'(sel[k]) == s);
    end

    for (genvar s = 0; s < NSCHED; s++) begin : g_space_chk
        AST_SPACE_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit[s]) <= int'(sched_space[s])); // R5
    end

    for (genvar k = 1; k < DEQ_W; k++) begin : g_age_chk
        AST_AGE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
            go[k] |-> cand_age[k] == cand_age[k-1] + AGE_W'(1)); // R10
    end

endmodule

// File: rtl/age_dispatch_buf.sv
module age_dispatch_buf
    import dbuf_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int ENQ_W  = 4,
    parameter  int DEQ_W  = 2,
    parameter  int NSCHED = 4,
    parameter  int DATA_W = 16,
    parameter  int SP_W   = 2,
    localparam int AGE_W  = $clog2(DEPTH) + 1,
    localparam int SEL_W  = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENQ_W-1:0]              map_valid,
    input  logic [ENQ_W-1:0][NSCHED-1:0]  map_mask,
    input  logic [ENQ_W-1:0][DATA_W-1:0]  map_data,
    output logic                          map_stall,
    input  logic [NSCHED-1:0][SP_W-1:0]   sched_space,
    output logic [DEQ_W-1:0]              iss_valid,
    output logic [DEQ_W-1:0][SEL_W-1:0]   iss_sched,
    output logic [DEQ_W-1:0][DATA_W-1:0]  iss_data,
    output logic [DEQ_W-1:0][AGE_W-1:0]   iss_age
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IN_CW  = $clog2(ENQ_W + 1);
    localparam int OUT_CW = $clog2(DEQ_W + 1);

    logic [CNT_W-1:0]             count;
    occ_state_e                   occ_state;
    logic [IN_CW-1:0]             n_push;
    logic [OUT_CW-1:0]            n_pop;
    logic [DEQ_W-1:0]             cand_valid;
    logic [DEQ_W-1:0][NSCHED-1:0] pk_mask;
    logic [DEQ_W-1:0][AGE_W-1:0]  pk_age;

    dbuf_occ_fsm #(
        .DEPTH(DEPTH), .ENQ_W(ENQ_W), .CNT_W(CNT_W),
        .IN_CW(IN_CW), .OUT_CW(OUT_CW)
    ) occ_i (
        .clk(clk), .rst_n(rst_n), .n_push(n_push), .n_pop(n_pop),
        .count(count), .state(occ_state), .map_stall(map_stall)
    );

    dbuf_store #(
        .DEPTH(DEPTH), .ENQ_W(ENQ_W), .DEQ_W(DEQ_W), .NSCHED(NSCHED),
        .DATA_W(DATA_W), .AGE_W(AGE_W), .IN_CW(IN_CW), .OUT_CW(OUT_CW)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .accept(!map_stall),
        .in_valid(map_valid), .in_mask(map_mask), .in_data(map_data),
        .n_pop(n_pop), .n_push(n_push),
        .pk_mask(pk_mask), .pk_data(iss_data), .pk_age(pk_age)
    );

    always_comb begin
        for (int k = 0; k < DEQ_W; k++) cand_valid[k] = int'(count) > k;
    end

    dbuf_pick #(
        .DEQ_W(DEQ_W), .NSCHED(NSCHED), .SP_W(SP_W), .SEL_W(SEL_W),
        .AGE_W(AGE_W), .OUT_CW(OUT_CW)
    ) pick_i (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid),
        .cand_mask(pk_mask), .cand_age(pk_age), .sched_space(sched_space),
        .go(iss_valid), .sel(iss_sched), .n_pop(n_pop)
    );

    assign iss_age = pk_age;

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        occ_state == OCC_EMPTY |-> iss_valid == '0); // R2
    AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid != '0 |-> iss_valid[0]); // R3
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !iss_valid[0]) |=> pk_age[0] == $past(pk_age[0])); // R4

endmodule

// File: tb/age_dispatch_buf_tb_top.sv
`timescale 1ns/1ps
module age_dispatch_buf_tb_top;
    localparam int DEPTH = 16, ENQ_W = 4, DEQ_W = 2, NSCHED = 4, DATA_W = 16, SP_W = 2;
    localparam int AGE_W = 5, SEL_W = 2, AGE_MOD = 32;

    // vector: {ops presented, mask for every op, space {s3,s2,s1,s0}}
    localparam logic [14:0] VECS [12] = '{
        {3'd3, 4'b1111, 8'b00_00_00_00},
        {3'd2, 4'b0011, 8'b00_00_01_01},
        {3'd4, 4'b1100, 8'b10_10_00_00},
        {3'd1, 4'b0101, 8'b01_00_00_10},
        {3'd0, 4'b1111, 8'b11_11_11_11},
        {3'd4, 4'b1000, 8'b00_01_10_11},
        {3'd4, 4'b0001, 8'b00_11_11_11},
        {3'd2, 4'b1010, 8'b10_00_00_00},
        {3'd3, 4'b0110, 8'b00_01_01_00},
        {3'd0, 4'b1111, 8'b01_01_01_01},
        {3'd4, 4'b1111, 8'b10_10_10_10},
        {3'd0, 4'b1111, 8'b11_11_11_11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ENQ_W-1:0]             map_valid = '0;
    logic [ENQ_W-1:0][NSCHED-1:0] map_mask = '0;
    logic [ENQ_W-1:0][DATA_W-1:0] map_data = '0;
    logic                         map_stall;
    logic [NSCHED-1:0][SP_W-1:0]  sched_space = '0;
    logic [DEQ_W-1:0]             iss_valid;
    logic [DEQ_W-1:0][SEL_W-1:0]  iss_sched;
    logic [DEQ_W-1:0][DATA_W-1:0] iss_data;
    logic [DEQ_W-1:0][AGE_W-1:0]  iss_age;

    int n_chk = 0;
    int n_bad = 0;
    int data_ctr = 1;
    int age_next = 0;
    logic [3:0]  q_mask [$];
    logic [15:0] q_data [$];
    int          q_age  [$];
    logic [DEQ_W-1:0] last_valid;
    logic             last_stall;
    logic [DEQ_W-1:0][SEL_W-1:0] last_sched;

    always #10 clk = ~clk;

    age_dispatch_buf dut_i (
        .clk(clk), .rst_n(rst_n), .map_valid(map_valid), .map_mask(map_mask),
        .map_data(map_data), .map_stall(map_stall), .sched_space(sched_space),
        .iss_valid(iss_valid), .iss_sched(iss_sched), .iss_data(iss_data),
        .iss_age(iss_age)
    );

    task automatic judge(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, compare with the model, update model
    task automatic step(input int n, input logic [3:0] m, input logic [7:0] sp);
        int  rem [NSCHED];
        bit  ev [DEQ_W];
        int  es [DEQ_W];
        bit  chain;
        bit  exp_stall;
        int  qs;
        int  pops;
        @(negedge clk);
        for (int i = 0; i < ENQ_W; i++) begin
            map_valid[i] = (i < n);
            map_mask[i]  = m;
            map_data[i]  = 16'(data_ctr + i);
        end
        sched_space = sp;
        #1;
        last_valid = iss_valid;
        last_stall = map_stall;
        last_sched = iss_sched;
        qs = q_mask.size();
        exp_stall = qs > DEPTH - ENQ_W;
        judge(map_stall == exp_stall, "R9", "stall", int'(map_stall), int'(exp_stall));
        for (int s = 0; s < NSCHED; s++) rem[s] = int'(sp[2*s +: 2]);
        chain = 1'b1;
        for (int k = 0; k < DEQ_W; k++) begin
            ev[k] = 1'b0;
            es[k] = 0;
            if (chain && k < qs) begin
                for (int s = 0; s < NSCHED; s++) begin
                    if (!ev[k] && q_mask[k][s] && rem[s] > 0) begin
                        ev[k] = 1'b1;
                        es[k] = s;
                        rem[s] = rem[s] - 1;
                    end
                end
            end
            chain = ev[k];
        end
        pops = 0;
        for (int k = 0; k < DEQ_W; k++) begin
            judge(iss_valid[k] == ev[k], "R3", "lane valid", int'(iss_valid[k]), int'(ev[k]));
            if (ev[k]) begin
                pops++;
                judge(int'(iss_sched[k]) == es[k], "R5", "target", int'(iss_sched[k]), es[k]);
                judge(iss_data[k] == q_data[k], "R8", "payload", int'(iss_data[k]), int'(q_data[k]));
                judge(int'(iss_age[k]) == q_age[k], "R10", "age", int'(iss_age[k]), q_age[k]);
            end
        end
        for (int p = 0; p < pops; p++) begin
            void'(q_mask.pop_front());
            void'(q_data.pop_front());
            void'(q_age.pop_front());
        end
        if (!exp_stall) begin
            for (int i = 0; i < n; i++) begin
                q_mask.push_back(m);
                q_data.push_back(16'(data_ctr + i));
                q_age.push_back(age_next % AGE_MOD);
                age_next++;
            end
        end
        data_ctr += n;
    endtask

    task automatic drain();
        for (int d = 0; d < 40 && q_mask.size() > 0; d++) step(0, 4'hf, 8'hff);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        judge(iss_valid == '0, "R1", "no issue after reset", int'(iss_valid), 0);
        judge(map_stall == 1'b0, "R1", "no stall after reset", int'(map_stall), 0);

        // R2 no bypass, R6 issue next cycle without readiness wait
        step(1, 4'b0001, 8'hff);
        judge(last_valid == '0, "R2", "same-cycle issue", int'(last_valid), 0);
        step(0, 4'b0001, 8'hff);
        judge(last_valid[0] == 1'b1, "R6", "next-cycle issue", int'(last_valid[0]), 1);

        // R4 younger op waits behind stuck oldest
        step(1, 4'b1000, 8'b00_11_11_11);
        step(1, 4'b0001, 8'b00_11_11_11);
        for (int c = 0; c < 3; c++) begin
            step(0, 4'b1111, 8'b00_11_11_11);
            judge(last_valid == '0, "R4", "blocked behind head", int'(last_valid), 0);
        end
        step(0, 4'b1111, 8'b01_00_00_01);
        judge(last_valid == 2'b11, "R4", "release both", int'(last_valid), 3);

        // R5 lowest-index choice and same-cycle space consumption
        step(2, 4'b0110, 8'b00_01_01_00);
        step(0, 4'b1111, 8'b00_01_01_00);
        judge(int'(last_sched[1]) == 2, "R5", "second op spills", int'(last_sched[1]), 2);
        step(1, 4'b0110, 8'b00_01_00_00);
        step(0, 4'b1111, 8'b00_01_00_00);
        judge(int'(last_sched[0]) == 2, "R5", "skip full sched", int'(last_sched[0]), 2);

        // R7 issue width
        step(4, 4'b1111, 8'h00);
        step(0, 4'b1111, 8'hff);
        judge($countones(last_valid) == DEQ_W, "R7", "issue width", $countones(last_valid), DEQ_W);
        drain();

        // R9 fill until stall, dropped group never appears
        for (int g = 0; g < 4; g++) step(4, 4'b1111, 8'h00);
        step(4, 4'b1111, 8'h00);
        judge(last_stall == 1'b1, "R9", "stall at full", int'(last_stall), 1);
        step(4, 4'b0001, 8'h00);
        drain();

        // table walk (R3 R5 R8 R10 via model)
        for (int pass = 0; pass < 2; pass++)
            for (int v = 0; v < 12; v++)
                step(int'(VECS[v][14:12]), VECS[v][11:8], VECS[v][7:0]);
        drain();
        judge(age_next > AGE_MOD, "R10", "age wrap exercised", age_next, AGE_MOD);
        step(0, 4'b1111, 8'hff);
        judge(last_valid == '0 && !last_stall, "R1", "idle after drain", int'(last_valid), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule